// File: doc/BRIEF.md
# Reloadable Up/Down Timer with Clock-Out

A 16-bit timer/counter for a peripheral subsystem. It advances on a prescaled clock-enable tick or on rising edges of an external count pin. It has four behaviours, chosen from a small control register: stopped, 16-bit capture, 16-bit auto-reload, and rate generator. In auto-reload it can count up only, or take its direction from a direction pin. A 16-bit reload/capture register, written from a bus, supplies the reload value. In capture mode it stores the timer value instead.

Rollovers set a sticky overflow flag, unless the timer is working as a rate generator. A second flag toggles on each rollover when the direction may change, so it acts as a 17th count bit. In capture mode that flag marks a capture instead. As a rate generator, the same rollovers drive a 50%-duty clock-out pin and divided transmit and receive baud ticks for a serial port, and these can all run at once.

Top module: `updn_reload_timer`

## Requirements
- R1: The control word is `{rx_baud[6], tx_baud[5], clkout_en[4], updn_en[3], capture_en[2], ext_count[1], run[0]}` and is loaded by `ctl_we_i`. With `run`=0 the timer holds its value in every mode.
- R2: With `ext_count`=0 the timer advances once per cycle in which `tick_i`=1. With `ext_count`=1 it advances once per rising edge of `cnt_pin_i`, and `tick_i` has no effect.
- R3: In auto-reload up counting (`updn_en`=0, or `updn_en`=1 with `dir_pin_i`=1), a step from 16'hFFFF loads the reload register value and sets `ovf_flag_o`. The flag stays set until `clr_ovf_i` is pulsed, and a set wins over a clear in the same cycle.
- R4: With `updn_en`=1 and `dir_pin_i`=0 the timer counts down. A down step taken while the timer equals the reload register loads 16'hFFFF and sets `ovf_flag_o`. With `updn_en`=0, `dir_pin_i` has no effect.
- R5: With `updn_en`=1 in auto-reload, `ext_flag_o` toggles on every overflow and every underflow. With `updn_en`=0, rollovers leave it unchanged.
- R6: In capture mode (`capture_en`=1, no generator select), a rising edge on `dir_pin_i` copies the timer into the reload/capture register and sets `ext_flag_o`, which `clr_ext_i` clears. A step from 16'hFFFF wraps the timer to 0 and sets `ovf_flag_o`.
- R7: Generator mode is active when `run`=1 and either `tx_baud` or `rx_baud` is set, or `clkout_en`=1 with `ext_count`=0. In this mode the timer counts up, a step from 16'hFFFF reloads it, and `ovf_flag_o` is never set.
- R8: With `clkout_en`=1, `ext_count`=0 and `run`=1, `clk_out_o` toggles on every rollover and holds at all other times, which gives a 50% duty cycle.
- R9: While `tx_baud` is set, `tx_tick_o` pulses for one cycle on every BAUD_DIV-th rollover. `rx_tick_o` does the same under `rx_baud`, and the two are independent. With the default BAUD_DIV=16 the tick rate is 1/8 of the clock-out frequency.
- R10: Reset clears the timer, the reload register, both flags, the control word, `clk_out_o` and both baud ticks.
- R11: `rld_we_i` loads `rld_wdata_i` into the reload/capture register, and `rld_o` reads it back. A bus write wins over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| cnt_pin_i | input | 1 | External count input, rising edges counted |
| dir_pin_i | input | 1 | Direction (1 up, 0 down) / capture trigger |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 7 | Control word |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | 16 | Reload register write data |
| clr_ovf_i | input | 1 | Clear overflow flag |
| clr_ext_i | input | 1 | Clear extra flag |
| timer_o | output | 16 | Timer value |
| rld_o | output | 16 | Reload/capture register value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Toggle / capture flag |
| clk_out_o | output | 1 | 50% duty clock output |
| tx_tick_o | output | 1 | Transmit baud tick |
| rx_tick_o | output | 1 | Receive baud tick |

## Verification
The bench builds the block with its defaults, WIDTH=16 and BAUD_DIV=16, so the 1/8 ratio between baud ticks and clock-out is checked as it would be used. A first overflow from zero would take 65536 steps. The bench avoids this by using one down-count underflow with a zero reload value, which places the timer at 16'hFFFF in a single step. From there, wraps in up-reload, capture and generator modes each come within one step. A reload value of 16'hFFFE gives a rollover every two ticks, so 16-rollover baud periods, clock-out duty and mode switching all fit into a few hundred cycles.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
  typedef struct packed {
    logic rx_baud;     // [6]
    logic tx_baud;     // [5]
    logic clkout_en;   // [4]
    logic updn_en;     // [3]
    logic capture_en;  // [2]
    logic ext_count;   // [1]
    logic run;         // [0]
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_CAPTURE,
    MODE_UP,
    MODE_DOWN,
    MODE_GEN
  } mode_e;
endpackage

// File: rtl/rtmr_edge.sv
`timescale 1ns/1ps
module rtmr_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = pin_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/rtmr_mode_dec.sv
`timescale 1ns/1ps
module rtmr_mode_dec import rtmr_pkg::*; (
  input  ctl_t  ctl_i,
  input  logic  dir_i,
  output mode_e mode_o
);
  logic gen;

  assign gen = ctl_i.tx_baud | ctl_i.rx_baud | (ctl_i.clkout_en & ~ctl_i.ext_count);

  always_comb begin
    if (!ctl_i.run)                     mode_o = MODE_OFF;
    else if (gen)                       mode_o = MODE_GEN;
    else if (ctl_i.capture_en)          mode_o = MODE_CAPTURE;
    else if (ctl_i.updn_en && !dir_i)   mode_o = MODE_DOWN;
    else                                mode_o = MODE_UP;
  end
endmodule

// File: rtl/rtmr_core.sv
`timescale 1ns/1ps
module rtmr_core import rtmr_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic         step_i,
  input  logic         cap_evt_i,
  input  logic         updn_en_i,
  input  logic         rld_we_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic         clr_ovf_i,
  input  logic         clr_ext_i,
  output logic [W-1:0] timer_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_o,
  output logic         ext_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] timer_q, rld_q;
  logic         ovf_q, ext_q;
  logic         up_mode, wrap_up, wrap_dn, reload_mode;

  assign up_mode     = (mode_i == MODE_UP) || (mode_i == MODE_GEN) || (mode_i == MODE_CAPTURE);
  assign reload_mode = (mode_i == MODE_UP) || (mode_i == MODE_DOWN);
  assign wrap_up     = step_i && up_mode && (timer_q == ALL1);
  assign wrap_dn     = step_i && (mode_i == MODE_DOWN) && (timer_q == rld_q);
  assign wrap_o      = wrap_up | wrap_dn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
    end else if (step_i && mode_i != MODE_OFF) begin
      unique case (mode_i)
        MODE_DOWN:    timer_q <= wrap_dn ? ALL1 : timer_q - W'(1);
        MODE_CAPTURE: timer_q <= timer_q + W'(1);
        default:      timer_q <= wrap_up ? rld_q : timer_q + W'(1);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   rld_q <= '0;
    else if (rld_we_i)                             rld_q <= rld_wdata_i;
    else if (cap_evt_i && mode_i == MODE_CAPTURE)  rld_q <= timer_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ovf_q <= 1'b0;
    else if (wrap_o && mode_i != MODE_GEN) ovf_q <= 1'b1;
    else if (clr_ovf_i)                    ovf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ext_q <= 1'b0;
    else if (cap_evt_i && mode_i == MODE_CAPTURE)   ext_q <= 1'b1;
    else if (wrap_o && reload_mode && updn_en_i)    ext_q <= ~ext_q;
    else if (clr_ext_i)                             ext_q <= 1'b0;
  end

  assign timer_o = timer_q;
  assign rld_o   = rld_q;
  assign ovf_o   = ovf_q;
  assign ext_o   = ext_q;
endmodule

// File: rtl/rtmr_outgen.sv
`timescale 1ns/1ps
module rtmr_outgen #(
  parameter int unsigned BAUD_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic clk_en_i,
  input  logic tx_en_i,
  input  logic rx_en_i,
  output logic clk_out_o,
  output logic tx_tick_o,
  output logic rx_tick_o
);
  localparam int unsigned CW = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);

  logic [CW-1:0] div_q;
  logic          baud_on, baud_hit;
  logic          clk_q, tx_q, rx_q;

  assign baud_on  = tx_en_i | rx_en_i;
  assign baud_hit = wrap_i && baud_on && (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (baud_hit)          div_q <= '0;
    else if (wrap_i && baud_on) div_q <= div_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0;
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      if (wrap_i && clk_en_i) clk_q <= ~clk_q;
      tx_q <= baud_hit & tx_en_i;
      rx_q <= baud_hit & rx_en_i;
    end
  end

  assign clk_out_o = clk_q;
  assign tx_tick_o = tx_q;
  assign rx_tick_o = rx_q;
endmodule

// File: rtl/updn_reload_timer.sv
`timescale 1ns/1ps
module updn_reload_timer import rtmr_pkg::*; #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned BAUD_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_pin_i,
  input  logic             dir_pin_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             rld_we_i,
  input  logic [WIDTH-1:0] rld_wdata_i,
  input  logic             clr_ovf_i,
  input  logic             clr_ext_i,
  output logic [WIDTH-1:0] timer_o,
  output logic [WIDTH-1:0] rld_o,
  output logic             ovf_flag_o,
  output logic             ext_flag_o,
  output logic             clk_out_o,
  output logic             tx_tick_o,
  output logic             rx_tick_o
);
  ctl_t        ctl_q;
  mode_e       mode;
  logic [1:0]  rise;
  logic        step, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i);
  end

  rtmr_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({dir_pin_i, cnt_pin_i}),
    .rise_o (rise)
  );

  rtmr_mode_dec u_dec (
    .ctl_i  (ctl_q),
    .dir_i  (dir_pin_i),
    .mode_o (mode)
  );

  assign step = ctl_q.run & (ctl_q.ext_count ? rise[0] : tick_i);

  rtmr_core #(.W(WIDTH)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .step_i      (step),
    .cap_evt_i   (rise[1]),
    .updn_en_i   (ctl_q.updn_en),
    .rld_we_i    (rld_we_i),
    .rld_wdata_i (rld_wdata_i),
    .clr_ovf_i   (clr_ovf_i),
    .clr_ext_i   (clr_ext_i),
    .timer_o     (timer_o),
    .rld_o       (rld_o),
    .ovf_o       (ovf_flag_o),
    .ext_o       (ext_flag_o),
    .wrap_o      (wrap)
  );

  rtmr_outgen #(.BAUD_DIV(BAUD_DIV)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .clk_en_i  (ctl_q.clkout_en & ~ctl_q.ext_count),
    .tx_en_i   (ctl_q.tx_baud),
    .rx_en_i   (ctl_q.rx_baud),
    .clk_out_o (clk_out_o),
    .tx_tick_o (tx_tick_o),
    .rx_tick_o (rx_tick_o)
  );
endmodule

// File: rtl/rtmr_chk.sv
`timescale 1ns/1ps
module rtmr_chk import rtmr_pkg::*; #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run,
  input logic         tx_en,
  input logic         rx_en,
  input mode_e        mode,
  input logic         step,
  input logic         wrap,
  input logic [W-1:0] timer,
  input logic [W-1:0] rld,
  input logic         ovf,
  input logic         clk_out,
  input logic         tx_tick,
  input logic         rx_tick
);
  localparam logic [W-1:0] ALL1 = '1;

  a_r1_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(timer));

  a_r3_up_wrap_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_UP && step && timer == ALL1) |=> (timer == $past(rld)) && ovf);

  a_r4_underflow_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DOWN && step && timer == rld) |=> (timer == ALL1) && ovf);

  a_r7_gen_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GEN && !ovf) |=> !ovf);

  a_r8_clkout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(clk_out));

  a_r9_tx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> !tx_tick);

  a_r9_rx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> !rx_tick);
endmodule

bind updn_reload_timer rtmr_chk #(.W(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (ctl_q.run),
  .tx_en   (ctl_q.tx_baud),
  .rx_en   (ctl_q.rx_baud),
  .mode    (mode),
  .step    (step),
  .wrap    (wrap),
  .timer   (timer_o),
  .rld     (rld_o),
  .ovf     (ovf_flag_o),
  .clk_out (clk_out_o),
  .tx_tick (tx_tick_o),
  .rx_tick (rx_tick_o)
);

// File: tb/updn_reload_timer_bench.sv
`timescale 1ns/1ps
module updn_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, cnt_pin_i = 1'b0, dir_pin_i = 1'b0;
  logic        ctl_we_i = 1'b0, rld_we_i = 1'b0, clr_ovf_i = 1'b0, clr_ext_i = 1'b0;
  logic [6:0]  ctl_wdata_i = '0;
  logic [15:0] rld_wdata_i = '0;
  logic [15:0] timer_o, rld_o;
  logic        ovf_flag_o, ext_flag_o, clk_out_o, tx_tick_o, rx_tick_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updn_reload_timer u_updn_reload_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .dir_pin_i(dir_pin_i), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .rld_we_i(rld_we_i), .rld_wdata_i(rld_wdata_i), .clr_ovf_i(clr_ovf_i),
    .clr_ext_i(clr_ext_i), .timer_o(timer_o), .rld_o(rld_o),
    .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .clk_out_o(clk_out_o),
    .tx_tick_o(tx_tick_o), .rx_tick_o(rx_tick_o)
  );

  typedef struct packed {
    logic [6:0]  ctl;
    logic        dir;
    logic [15:0] rld;
    logic [7:0]  n;
    logic [15:0] t;
    logic        ovf;
    logic        ext;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{7'h01, 1'b1, 16'h1234, 8'd10, 16'h000A, 1'b0, 1'b0},  // R2 up by tick
    '{7'h00, 1'b1, 16'h1234, 8'd10, 16'h0000, 1'b0, 1'b0},  // R1 stopped
    '{7'h09, 1'b0, 16'h0000, 8'd3,  16'hFFFD, 1'b1, 1'b1},  // R4 underflow at 0
    '{7'h09, 1'b0, 16'hFFFA, 8'd7,  16'hFFFF, 1'b1, 1'b1},  // R4 underflow at FFFA
    '{7'h01, 1'b0, 16'h0000, 8'd3,  16'h0003, 1'b0, 1'b0},  // R4 dir ignored
    '{7'h09, 1'b1, 16'h0000, 8'd5,  16'h0005, 1'b0, 1'b0},  // R4 up by dir
    '{7'h05, 1'b1, 16'h0000, 8'd4,  16'h0004, 1'b0, 1'b0}   // R6 capture counts
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick_i = 0; cnt_pin_i = 0; dir_pin_i = 0; ctl_we_i = 0; rld_we_i = 0;
    clr_ovf_i = 0; clr_ext_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [6:0] v);
    ctl_we_i = 1; ctl_wdata_i = v; @(negedge clk); ctl_we_i = 0;
  endtask

  task automatic wr_rld(input logic [15:0] v);
    rld_we_i = 1; rld_wdata_i = v; @(negedge clk); rld_we_i = 0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1; repeat (n) @(negedge clk); tick_i = 0;
  endtask

  task automatic pulse_clr_ovf();
    clr_ovf_i = 1; @(negedge clk); clr_ovf_i = 0;
  endtask

  // brings timer to FFFF through one underflow with reload 0
  task automatic park_at_ffff();
    wr_rld(16'h0000); dir_pin_i = 0; wr_ctl(7'h09); ticks(1);
  endtask

  initial begin
    int tog, hi, txn, rxn, ovfs;
    logic prev;

    // R10 reset state
    do_reset();
    chk("R10 timer", timer_o, 0);
    chk("R10 rld", rld_o, 0);
    chk("R10 flags/outs", {ovf_flag_o, ext_flag_o, clk_out_o, tx_tick_o, rx_tick_o}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      dir_pin_i = VECS[i].dir;
      wr_rld(VECS[i].rld);
      wr_ctl(VECS[i].ctl);
      ticks(int'(VECS[i].n));
      chk($sformatf("R11 vec%0d rld", i), rld_o, VECS[i].rld);
      chk($sformatf("R1/R2/R4 vec%0d timer", i), timer_o, VECS[i].t);
      chk($sformatf("R3/R4 vec%0d ovf", i), ovf_flag_o, VECS[i].ovf);
      chk($sformatf("R5 vec%0d ext", i), ext_flag_o, VECS[i].ext);
    end

    // R3 R5 up reload, stickiness, toggle
    do_reset();
    park_at_ffff();
    chk("R4 park timer", timer_o, 16'hFFFF);
    repeat (3) @(negedge clk);
    chk("R3 ovf sticky", ovf_flag_o, 1);
    pulse_clr_ovf();
    chk("R3 ovf cleared", ovf_flag_o, 0);
    wr_rld(16'hFFF0);
    dir_pin_i = 1;
    ticks(1);
    chk("R3 up wrap reload", timer_o, 16'hFFF0);
    chk("R3 up wrap ovf", ovf_flag_o, 1);
    chk("R5 ext toggled back", ext_flag_o, 0);
    pulse_clr_ovf();
    wr_ctl(7'h01);
    ticks(16);
    chk("R3 up-only wrap reload", timer_o, 16'hFFF0);
    chk("R3 up-only ovf", ovf_flag_o, 1);
    chk("R5 ext unchanged updn_en=0", ext_flag_o, 0);

    // R2 external count pin, tick ignored
    do_reset();
    wr_ctl(7'h03);
    tick_i = 1;
    for (int k = 0; k < 5; k++) begin
      cnt_pin_i = 1; repeat (2) @(negedge clk);
      cnt_pin_i = 0; repeat (2) @(negedge clk);
    end
    tick_i = 0;
    chk("R2 pin edges counted", timer_o, 5);

    // R6 capture
    do_reset();
    wr_ctl(7'h05);
    ticks(20);
    dir_pin_i = 1;
    @(negedge clk);
    chk("R6 capture value", rld_o, 16'h0014);
    chk("R6 capture flag", ext_flag_o, 1);
    chk("R6 timer unaffected", timer_o, 16'h0014);
    clr_ext_i = 1; @(negedge clk); clr_ext_i = 0;
    chk("R6 ext cleared", ext_flag_o, 0);

    // R6 capture wrap to zero
    do_reset();
    park_at_ffff();
    dir_pin_i = 1; @(negedge clk);
    wr_ctl(7'h05);
    pulse_clr_ovf();
    ticks(1);
    chk("R6 wrap to zero", timer_o, 0);
    chk("R6 wrap ovf", ovf_flag_o, 1);
    chk("R6 no capture w/o edge", rld_o, 0);

    // R7 R8 R9 generator: clock-out plus transmit baud
    do_reset();
    park_at_ffff();
    wr_rld(16'hFFFE);
    wr_ctl(7'h31);
    pulse_clr_ovf();
    tog = 0; hi = 0; txn = 0; rxn = 0; ovfs = 0; prev = clk_out_o;
    tick_i = 1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (clk_out_o != prev) tog++;
      prev = clk_out_o;
      hi += int'(clk_out_o);
      txn += int'(tx_tick_o);
      rxn += int'(rx_tick_o);
      ovfs += int'(ovf_flag_o);
    end
    tick_i = 0;
    chk("R8 clk_out toggles", tog, 32);
    chk("R8 clk_out duty", hi, 32);
    chk("R9 tx ticks (1/8 clk_out)", txn, 2);
    chk("R9 rx idle", rxn, 0);
    chk("R7 no ovf in gen", ovfs, 0);

    // R9 receive only, clock-out off
    wr_ctl(7'h41);
    tog = 0; txn = 0; rxn = 0; ovfs = 0; prev = clk_out_o;
    tick_i = 1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (clk_out_o != prev) tog++;
      prev = clk_out_o;
      txn += int'(tx_tick_o);
      rxn += int'(rx_tick_o);
      ovfs += int'(ovf_flag_o);
    end
    tick_i = 0;
    chk("R9 rx ticks", rxn, 2);
    chk("R9 tx idle", txn, 0);
    chk("R8 clk_out held when disabled", tog, 0);
    chk("R7 no ovf in baud", ovfs, 0);

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule